// File: doc/BRIEF.md
# Pointer-Addressed Stack Machine Memory Unit

This block is the memory-access datapath and sequencer of a small dual-stack processor. Every memory address comes from one of three pointer registers: the program pointer P, the return-stack top R, or the general address register A. The data stack never supplies an address. The only word that moves between the data stack and memory is T, the top of the data stack. A store therefore removes one item from the data stack, where a conventional stack store would remove two, and every operation completes in a single clock.

The unit holds T with a circular data stack below it, R with a circular return stack below it, P, A and an instruction register I. A single address incrementer sits on the memory address bus, and every post-increment uses it, including the advance of P. A decoded 4-bit operation code arrives each cycle. The unit drives a single-port synchronous memory whose read data is valid within the same cycle. The return operation fetches the next instruction word through R in one cycle. In that same cycle it moves the incremented address into P and pops the return stack.

Top module: `ptr_mem_unit`

## Requirements
- R1: A synchronous active-high reset makes P, A, R, T and I read zero on the next clock edge, and empties both stacks.
- R2: The memory address is P for LIT (code 1) and for every non-memory code, R for codes 2, 3 and 12, and A for codes 4 to 7. The write data always equals T.
- R3: LIT (code 1) pushes the word read at P as the new T and advances P by one.
- R4: Code 2 pushes the word read at R and advances R. Code 3 writes T at R, pops the data stack and advances R.
- R5: Code 4 pushes the word read at A and leaves A unchanged. Code 5 does the same and then advances A by one.
- R6: Code 6 writes T at A and pops the data stack. Code 7 does the same and then advances A by one.
- R7: Write enable is high only for codes 3, 6 and 7.
- R8: Code 8 pops T into A. Code 9 pushes A onto the data stack.
- R9: Code 10 pops T into R and pushes the old R onto the return stack. Code 11 pushes R onto the data stack and pops the return stack into R.
- R10: Return (code 12) completes in one cycle. I takes the word read at R, P becomes R+1, and the return stack pops into R. T is unchanged.
- R11: CALL (code 13) pushes R onto the return stack, copies P into R, loads P from T and pops the data stack.
- R12: Both stacks hold eight entries below their top register and wrap circularly without flags. After nine pushes followed by nine pops, the top reads the eighth pushed value.
- R13: Codes 0, 14 and 15 leave P, A, R and T unchanged and do not write memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Decoded operation code |
| mem_rdata | input | 16 | Memory read word, valid in the same cycle |
| mem_addr | output | 16 | Memory address, taken from P, R or A |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write word (T) |
| t_out | output | 16 | Top of data stack |
| r_out | output | 16 | Top of return stack |
| p_out | output | 16 | Program pointer |
| a_out | output | 16 | Address register |
| i_out | output | 16 | Instruction register |

## Verification
The memory address, write enable and write word are combinational from the operation code and the current registers, so they are due in the same cycle as the code. The bench samples them one time step after it drives the code. T, P, A, R and I pass through exactly one register, so they change at the first rising edge after the code is applied. The bench reads them at the following falling edge, before it drives the next code. Memory contents written by stores are read back from the bench's memory model one edge after the store. Stack wrap is observed through the top registers after a full sequence of pushes and pops.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

   typedef enum logic [3:0] {
      OP_NOP         = 4'd0,
      OP_LIT         = 4'd1,
      OP_LD_R_INC    = 4'd2,
      OP_ST_R_INC    = 4'd3,
      OP_LD_A        = 4'd4,
      OP_LD_A_INC    = 4'd5,
      OP_ST_A        = 4'd6,
      OP_ST_A_INC    = 4'd7,
      OP_T_TO_A      = 4'd8,
      OP_A_TO_T      = 4'd9,
      OP_T_TO_R      = 4'd10,
      OP_R_TO_T      = 4'd11,
      OP_RET         = 4'd12,
      OP_CALL        = 4'd13
   } op_e;

   typedef enum logic [1:0] {ASEL_P, ASEL_R, ASEL_A} addr_sel_e;
   typedef enum logic [2:0] {TS_HOLD, TS_MEM, TS_A, TS_R, TS_NEXT} t_sel_e;
   typedef enum logic [2:0] {RS_HOLD, RS_INC, RS_T, RS_P, RS_UNDER} r_sel_e;
   typedef enum logic [1:0] {PS_HOLD, PS_INC, PS_T} p_sel_e;
   typedef enum logic [1:0] {AS_HOLD, AS_INC, AS_T} a_sel_e;

   typedef struct packed {
      addr_sel_e asel;
      t_sel_e    tsel;
      r_sel_e    rsel;
      p_sel_e    psel;
      a_sel_e    aupd;
      logic      ds_push;
      logic      ds_pop;
      logic      rs_push;
      logic      rs_pop;
      logic      we;
      logic      ir_load;
   } ctl_t;

endpackage

// File: rtl/pmu_decode.sv
module pmu_decode
   import pmu_pkg::*;
(
   input  logic [3:0] op,
   output ctl_t       ctl
);

   always_comb begin
      ctl = '0;
      ctl.asel = ASEL_P;
      unique case (op)
         OP_LIT: begin
            ctl.asel = ASEL_P;  ctl.ds_push = 1'b1;
            ctl.tsel = TS_MEM;  ctl.psel    = PS_INC;
         end
         OP_LD_R_INC: begin
            ctl.asel = ASEL_R;  ctl.ds_push = 1'b1;
            ctl.tsel = TS_MEM;  ctl.rsel    = RS_INC;
         end
         OP_ST_R_INC: begin
            ctl.asel = ASEL_R;  ctl.we      = 1'b1;
            ctl.ds_pop = 1'b1;  ctl.tsel    = TS_NEXT;
            ctl.rsel = RS_INC;
         end
         OP_LD_A, OP_LD_A_INC: begin
            ctl.asel = ASEL_A;  ctl.ds_push = 1'b1;
            ctl.tsel = TS_MEM;
            ctl.aupd = (op == OP_LD_A_INC) ? AS_INC : AS_HOLD;
         end
         OP_ST_A, OP_ST_A_INC: begin
            ctl.asel = ASEL_A;  ctl.we      = 1'b1;
            ctl.ds_pop = 1'b1;  ctl.tsel    = TS_NEXT;
            ctl.aupd = (op == OP_ST_A_INC) ? AS_INC : AS_HOLD;
         end
         OP_T_TO_A: begin
            ctl.ds_pop = 1'b1;  ctl.tsel = TS_NEXT;  ctl.aupd = AS_T;
         end
         OP_A_TO_T: begin
            ctl.ds_push = 1'b1; ctl.tsel = TS_A;
         end
         OP_T_TO_R: begin
            ctl.ds_pop  = 1'b1; ctl.tsel = TS_NEXT;
            ctl.rs_push = 1'b1; ctl.rsel = RS_T;
         end
         OP_R_TO_T: begin
            ctl.ds_push = 1'b1; ctl.tsel = TS_R;
            ctl.rs_pop  = 1'b1; ctl.rsel = RS_UNDER;
         end
         OP_RET: begin
            ctl.asel    = ASEL_R;  ctl.ir_load = 1'b1;
            ctl.psel    = PS_INC;  ctl.rs_pop  = 1'b1;
            ctl.rsel    = RS_UNDER;
         end
         OP_CALL: begin
            ctl.ds_pop  = 1'b1; ctl.tsel = TS_NEXT;
            ctl.rs_push = 1'b1; ctl.rsel = RS_P;
            ctl.psel    = PS_T;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pmu_addr_path.sv
module pmu_addr_path
   import pmu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  addr_sel_e         asel,
   input  logic [WIDTH-1:0]  p_q,
   input  logic [WIDTH-1:0]  r_q,
   input  logic [WIDTH-1:0]  a_q,
   output logic [WIDTH-1:0]  addr,
   output logic [WIDTH-1:0]  addr_nx
);

   always_comb begin
      unique case (asel)
         ASEL_R:  addr = r_q;
         ASEL_A:  addr = a_q;
         default: addr = p_q;
      endcase
   end

   // the one incrementer shared by every post-increment
   assign addr_nx = addr + WIDTH'(1);

endmodule

// File: rtl/pmu_stack.sv
module pmu_stack #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] under
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pmu_stack: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [PW-1:0]    sp;
   logic [PW-1:0]    top_idx;
   logic [WIDTH-1:0] ent [DEPTH];

   assign top_idx = sp - PW'(1);
   assign under   = ent[top_idx];

   always_ff @(posedge clk) begin
      if (rst)       sp <= '0;
      else if (push) sp <= sp + PW'(1);
      else if (pop)  sp <= top_idx;
   end

   always_ff @(posedge clk) begin
      if (!rst && push) ent[sp] <= din;
   end

endmodule

// File: rtl/ptr_mem_unit.sv
module ptr_mem_unit
   import pmu_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int DS_DEPTH = 8,
   parameter int RS_DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] mem_rdata,
   output logic [WIDTH-1:0] mem_addr,
   output logic             mem_we,
   output logic [WIDTH-1:0] mem_wdata,
   output logic [WIDTH-1:0] t_out,
   output logic [WIDTH-1:0] r_out,
   output logic [WIDTH-1:0] p_out,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] i_out
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("ptr_mem_unit: WIDTH must be at least 2");
      end
   endgenerate

   ctl_t             ctl;
   logic [WIDTH-1:0] t_q, r_q, p_q, a_q, i_q;
   logic [WIDTH-1:0] addr, addr_nx;
   logic [WIDTH-1:0] ds_under, rs_under;

   pmu_decode u_dec (
      .op  (op),
      .ctl (ctl)
   );

   pmu_addr_path #(.WIDTH(WIDTH)) u_addr (
      .asel    (ctl.asel),
      .p_q     (p_q),
      .r_q     (r_q),
      .a_q     (a_q),
      .addr    (addr),
      .addr_nx (addr_nx)
   );

   pmu_stack #(.WIDTH(WIDTH), .DEPTH(DS_DEPTH)) u_dstk (
      .clk   (clk),
      .rst   (rst),
      .push  (ctl.ds_push),
      .pop   (ctl.ds_pop),
      .din   (t_q),
      .under (ds_under)
   );

   pmu_stack #(.WIDTH(WIDTH), .DEPTH(RS_DEPTH)) u_rstk (
      .clk   (clk),
      .rst   (rst),
      .push  (ctl.rs_push),
      .pop   (ctl.rs_pop),
      .din   (r_q),
      .under (rs_under)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         t_q <= '0;
         r_q <= '0;
         p_q <= '0;
         a_q <= '0;
         i_q <= '0;
      end else begin
         unique case (ctl.tsel)
            TS_MEM:  t_q <= mem_rdata;
            TS_A:    t_q <= a_q;
            TS_R:    t_q <= r_q;
            TS_NEXT: t_q <= ds_under;
            default: ;
         endcase
         unique case (ctl.rsel)
            RS_INC:   r_q <= addr_nx;
            RS_T:     r_q <= t_q;
            RS_P:     r_q <= p_q;
            RS_UNDER: r_q <= rs_under;
            default:  ;
         endcase
         unique case (ctl.psel)
            PS_INC:  p_q <= addr_nx;
            PS_T:    p_q <= t_q;
            default: ;
         endcase
         unique case (ctl.aupd)
            AS_INC:  a_q <= addr_nx;
            AS_T:    a_q <= t_q;
            default: ;
         endcase
         if (ctl.ir_load) i_q <= mem_rdata;
      end
   end

   assign mem_addr  = addr;
   assign mem_we    = ctl.we;
   assign mem_wdata = t_q;
   assign t_out     = t_q;
   assign r_out     = r_q;
   assign p_out     = p_q;
   assign a_out     = a_q;
   assign i_out     = i_q;

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst,
   input logic [3:0]       op,
   input logic [WIDTH-1:0] mem_rdata,
   input logic [WIDTH-1:0] mem_addr,
   input logic             mem_we,
   input logic [WIDTH-1:0] mem_wdata,
   input logic [WIDTH-1:0] t_out,
   input logic [WIDTH-1:0] r_out,
   input logic [WIDTH-1:0] p_out,
   input logic [WIDTH-1:0] a_out,
   input logic [WIDTH-1:0] i_out
);

   // R1
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (t_out == '0 && r_out == '0 && p_out == '0 && a_out == '0 && i_out == '0));

   // R7
   a_r7_we_store_only: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (op == 4'd3 || op == 4'd6 || op == 4'd7));

   // R2
   a_r2_wdata_is_t: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> mem_wdata == t_out);

   a_r2_lit_from_p: assert property (@(posedge clk) disable iff (rst)
      op == 4'd1 |-> mem_addr == p_out);

   a_r2_a_ops_from_a: assert property (@(posedge clk) disable iff (rst)
      (op >= 4'd4 && op <= 4'd7) |-> mem_addr == a_out);

   // R3
   a_r3_lit_step: assert property (@(posedge clk) disable iff (rst)
      op == 4'd1 |=> (p_out == WIDTH'($past(p_out) + 1'b1) && t_out == $past(mem_rdata)));

   // R5
   a_r5_fetch_a_hold: assert property (@(posedge clk) disable iff (rst)
      op == 4'd4 |=> a_out == $past(a_out));

   // R10
   a_r10_ret_one_cycle: assert property (@(posedge clk) disable iff (rst)
      op == 4'd12 |=> (i_out == $past(mem_rdata) && p_out == WIDTH'($past(r_out) + 1'b1)
                       && t_out == $past(t_out)));

   // R13
   a_r13_idle_codes: assert property (@(posedge clk) disable iff (rst)
      (op == 4'd0 || op == 4'd14 || op == 4'd15) |=> $stable({t_out, p_out, a_out, r_out}));

endmodule

bind ptr_mem_unit pmu_checker #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .op        (op),
   .mem_rdata (mem_rdata),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .mem_wdata (mem_wdata),
   .t_out     (t_out),
   .r_out     (r_out),
   .p_out     (p_out),
   .a_out     (a_out),
   .i_out     (i_out)
);

// File: tb/ptr_mem_unit_tb.sv
module ptr_mem_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam int NVEC       = 18;

   typedef struct packed {
      logic [3:0]   op;
      logic [W-1:0] addr;
      logic         we;
      logic [W-1:0] wd;
      logic [W-1:0] t;
      logic [W-1:0] p;
      logic [W-1:0] a;
      logic [W-1:0] r;
   } vec_t;

   // memory word k starts as 16'h1000 + (k << 4); index = address[5:0]
   localparam vec_t VEC [NVEC] = '{
      '{4'd1,  16'h0000, 1'b0, 16'h0000, 16'h1000, 16'h0001, 16'h0000, 16'h0000},
      '{4'd1,  16'h0001, 1'b0, 16'h0000, 16'h1010, 16'h0002, 16'h0000, 16'h0000},
      '{4'd8,  16'h0002, 1'b0, 16'h0000, 16'h1000, 16'h0002, 16'h1010, 16'h0000},
      '{4'd5,  16'h1010, 1'b0, 16'h0000, 16'h1100, 16'h0002, 16'h1011, 16'h0000},
      '{4'd4,  16'h1011, 1'b0, 16'h0000, 16'h1110, 16'h0002, 16'h1011, 16'h0000},
      '{4'd6,  16'h1011, 1'b1, 16'h1110, 16'h1100, 16'h0002, 16'h1011, 16'h0000},
      '{4'd7,  16'h1011, 1'b1, 16'h1100, 16'h1000, 16'h0002, 16'h1012, 16'h0000},
      '{4'd9,  16'h0002, 1'b0, 16'h0000, 16'h1012, 16'h0002, 16'h1012, 16'h0000},
      '{4'd10, 16'h0002, 1'b0, 16'h0000, 16'h1000, 16'h0002, 16'h1012, 16'h1012},
      '{4'd2,  16'h1012, 1'b0, 16'h0000, 16'h1120, 16'h0002, 16'h1012, 16'h1013},
      '{4'd3,  16'h1013, 1'b1, 16'h1120, 16'h1000, 16'h0002, 16'h1012, 16'h1014},
      '{4'd11, 16'h0002, 1'b0, 16'h0000, 16'h1014, 16'h0002, 16'h1012, 16'h0000},
      '{4'd13, 16'h0002, 1'b0, 16'h0000, 16'h1000, 16'h1014, 16'h1012, 16'h0002},
      '{4'd1,  16'h1014, 1'b0, 16'h0000, 16'h1140, 16'h1015, 16'h1012, 16'h0002},
      '{4'd12, 16'h0002, 1'b0, 16'h0000, 16'h1140, 16'h0003, 16'h1012, 16'h0000},
      '{4'd0,  16'h0003, 1'b0, 16'h0000, 16'h1140, 16'h0003, 16'h1012, 16'h0000},
      '{4'd14, 16'h0003, 1'b0, 16'h0000, 16'h1140, 16'h0003, 16'h1012, 16'h0000},
      '{4'd15, 16'h0003, 1'b0, 16'h0000, 16'h1140, 16'h0003, 16'h1012, 16'h0000}
   };

   logic         clk = 1'b0;
   logic         rst;
   logic [3:0]   op;
   logic [W-1:0] mem_rdata, mem_addr, mem_wdata;
   logic         mem_we;
   logic [W-1:0] t_out, r_out, p_out, a_out, i_out;
   logic [W-1:0] mem [64];

   logic [W-1:0] seen_addr, seen_wd;
   logic         seen_we;
   int           n_checks = 0;
   int           n_errors = 0;
   bit           done     = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign mem_rdata = mem[mem_addr[5:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;

   ptr_mem_unit u_dut (
      .clk       (clk),
      .rst       (rst),
      .op        (op),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .t_out     (t_out),
      .r_out     (r_out),
      .p_out     (p_out),
      .a_out     (a_out),
      .i_out     (i_out)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive after a falling edge; combinational outputs sampled 1 step later,
   // registered outputs valid at the next falling edge
   task automatic do_op(input logic [3:0] o);
      op = o;
      #1;
      seen_addr = mem_addr;
      seen_we   = mem_we;
      seen_wd   = mem_wdata;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      op  = 4'd0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   function automatic string tag_of(input logic [3:0] o);
      case (o)
         4'd1:          return "R3";
         4'd2, 4'd3:    return "R4";
         4'd4, 4'd5:    return "R5";
         4'd6, 4'd7:    return "R6";
         4'd8, 4'd9:    return "R8";
         4'd10, 4'd11:  return "R9";
         4'd12:         return "R10";
         4'd13:         return "R11";
         default:       return "R13";
      endcase
   endfunction

   initial begin
      for (int k = 0; k < 64; k++) mem[k] = 16'h1000 + W'(k << 4);
      do_reset();
      // R1: reset state
      check("R1 t", t_out, 16'h0);
      check("R1 p", p_out, 16'h0);
      check("R1 a", a_out, 16'h0);
      check("R1 r", r_out, 16'h0);
      check("R1 i", i_out, 16'h0);

      for (int v = 0; v < NVEC; v++) begin
         do_op(VEC[v].op);
         check("R2 addr", seen_addr, VEC[v].addr);
         check("R7 we", {15'h0, seen_we}, {15'h0, VEC[v].we});
         if (VEC[v].we) check("R2 wdata", seen_wd, VEC[v].wd);
         check({tag_of(VEC[v].op), " t"}, t_out, VEC[v].t);
         check({tag_of(VEC[v].op), " p"}, p_out, VEC[v].p);
         check({tag_of(VEC[v].op), " a"}, a_out, VEC[v].a);
         check({tag_of(VEC[v].op), " r"}, r_out, VEC[v].r);
      end

      // R10: instruction word latched from memory word 2
      check("R10 i", i_out, 16'h1020);
      // R6 / R4: stored words landed in memory
      check("R6 mem17", mem[17], 16'h1100);
      check("R4 mem19", mem[19], 16'h1120);

      // R1: reset in the middle of a run
      do_reset();
      check("R1 p mid", p_out, 16'h0);
      check("R1 a mid", a_out, 16'h0);
      check("R1 i mid", i_out, 16'h0);

      // R12: data stack wraps after nine pushes
      for (int k = 0; k < 9; k++) do_op(4'd1);
      check("R12 ds top", t_out, 16'h1080);
      for (int k = 0; k < 8; k++) do_op(4'd8);
      check("R12 ds 8 pops", t_out, 16'h1000);
      do_op(4'd8);
      check("R12 ds wrap", t_out, 16'h1070);

      // R12: return stack wraps after nine pushes
      do_reset();
      for (int k = 0; k < 9; k++) begin
         do_op(4'd1);
         do_op(4'd10);
      end
      check("R12 rs top", r_out, 16'h1080);
      for (int k = 0; k < 8; k++) do_op(4'd11);
      check("R12 rs 8 pops", r_out, 16'h1000);
      do_op(4'd11);
      check("R12 rs wrap", r_out, 16'h1070);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule